// File: doc/BRIEF.md
# Link Equalization Phase Sequencer

This block sequences the two late phases of 8 GT/s link equalization on one end of a link. A static role input selects root (upstream) or endpoint (downstream) behaviour. A phase-2 entry strobe loads the starting preset and opens the tuning loop. In the loop an external evaluator offers candidate transmitter coefficient sets. The block screens each candidate against the three coefficient rules, presents an accepted set to the link partner and holds it until the partner acknowledges. A bit-error-rate-good indication from the receiver ends the loop.

In phase 3 an endpoint runs the same loop a second time, now on the sets the root asks it to apply. A root only waits for its own receiver to settle and never tunes the endpoint's transmitter. The block then enters receiver-lock recovery. It sends equalization-control code 00 and latches the agreed coefficient set, which stays stable until the next lock entry.

An iteration limit or an external timeout strobe ends a loop that does not converge, with an error flag set. A one-shot adaptive equalization enable is raised only in the phase where this end's receiver is being tuned. Any rate downshift request kills that enable until the next phase-2 entry.

Top module: `eq_phase_seq`

## Requirements
- R1: A p2_enter pulse, from any state, moves the block to phase 2 on the next clock: phase = 2, ec_out = 2'b10, coef_out = init_coef, coef_req = 0, eq_err = 0.
- R2: In a tuning loop (phase 2, or phase 3 with is_root = 0), when no request is pending and the loop has not converged, a legal candidate (cand_vld = 1) is copied to coef_out and coef_req goes to 1 on the next clock. coef_req stays high until the cycle after coef_ack, and the accepted set counts as one iteration.
- R3: Coefficient fields are packed as pre = bits [CW-1:0], main = [2CW-1:CW], post = [3CW-1:2CW], all unsigned. A set is legal only if pre <= floor(fs/4), pre + main + post = fs, and main - pre - post >= lf. An illegal candidate is ignored, and so is any candidate while coef_req = 1: coef_out and coef_req stay unchanged.
- R4: ber_ok = 1 in a loop with no pending request marks the loop converged, and later candidates are ignored. If ber_ok and cand_vld arrive in the same cycle, convergence wins and the candidate is dropped.
- R5: p3_enter is honoured only in phase 2 after convergence. The block then moves to phase 3 (ec_out = 2'b11), and an endpoint reloads coef_out from init_coef. p3_enter before convergence is ignored.
- R6: A root in phase 3 accepts no candidate (coef_req stays 0, coef_out keeps the phase-2 set). Its ber_ok enters receiver-lock recovery.
- R7: An endpoint whose phase-3 loop converges enters receiver-lock recovery with final_coef = the last set it applied in phase 3. A root's final_coef is the last set applied in phase 2.
- R8: In receiver-lock recovery rcvr_lock = 1, phase = 1 and ec_out = 2'b00. final_coef changes only on lock entry, and candidates, acks, timeouts and p2_enter leave it unchanged.
- R9: With iter_lim = L, a candidate of any kind that arrives in a loop after L accepted sets, with no pending request and no ber_ok, enters lock recovery with eq_err = 1. final_coef is then the last accepted set, or init_coef when L = 0.
- R10: A timeout pulse in phase 2 or 3 enters lock recovery on the next clock with eq_err = 1 and final_coef = current coef_out.
- R11: aeq_en is 1 only for an endpoint in phase 2 or a root in phase 3, and 0 in every other state and role.
- R12: rate_dn = 1 forces aeq_en to 0 in the same cycle. aeq_en stays 0 until a later p2_enter that does not coincide with rate_dn.
- R13: After reset phase = 0 and ec_out, aeq_en, coef_req, coef_out, final_coef, rcvr_lock and eq_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_root | input | 1 | 1 = root (upstream) role, 0 = endpoint |
| p2_enter | input | 1 | Strobe: enter phase 2 (remote transmitter tuning) |
| p3_enter | input | 1 | Strobe: enter phase 3 (local transmitter tuning) |
| init_coef | input | 3*CW | Starting preset coefficients loaded on phase entry |
| fs | input | CW | Full-swing value for the legality rules |
| lf | input | CW | Low-frequency limit for the legality rules |
| cand_vld | input | 1 | Candidate coefficient set offered |
| cand_coef | input | 3*CW | Candidate set {post, main, pre} |
| coef_ack | input | 1 | Partner has applied the requested set |
| ber_ok | input | 1 | Receiver reports error rate below target |
| timeout | input | 1 | External phase timeout strobe |
| iter_lim | input | IW | Maximum accepted sets per loop |
| rate_dn | input | 1 | Request to drop from 8 GT/s to a lower rate |
| phase | output | 2 | 0 idle, 1 lock recovery, 2 phase 2, 3 phase 3 |
| ec_out | output | 2 | Equalization-control code to send |
| aeq_en | output | 1 | One-shot adaptive equalization enable |
| coef_req | output | 1 | Request pending toward the partner |
| coef_out | output | 3*CW | Current applied coefficient set |
| final_coef | output | 3*CW | Agreed set latched at lock entry |
| rcvr_lock | output | 1 | In receiver-lock recovery |
| eq_err | output | 1 | Loop ended by iteration limit or timeout |

## Verification
Two collisions matter most. A convergence report can land in the same cycle as a new candidate, and the iteration-limit exit can land in the same cycle as a convergence report. The bench drives ber_ok and cand_vld together in an open loop. It then expects coef_out to keep the preset, coef_req to stay low and later candidates to be refused. It also drives a rate downshift together with a phase-2 entry for an endpoint and judges that aeq_en stays low in phase 2 until a clean re-entry.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOCK = 2'd1,
    ST_P2   = 2'd2,
    ST_P3   = 2'd3
  } st_t;

  // phase in which this end's own receiver is being adapted
  function automatic logic aeq_wanted(st_t s, logic root);
    return root ? (s == ST_P3) : (s == ST_P2);
  endfunction

  function automatic logic [1:0] ec_of(st_t s);
    return (s == ST_P2 || s == ST_P3) ? 2'(s) : 2'b00;
  endfunction
endpackage

// File: rtl/eqs_legal.sv
module eqs_legal #(
  parameter int CW = 5
) (
  input  logic [3*CW-1:0] coef,
  input  logic [CW-1:0]   fs,
  input  logic [CW-1:0]   lf,
  output logic            ok
);
  localparam int SW = CW + 2;

  function automatic logic rules_met(input logic [CW-1:0] pre, input logic [CW-1:0] main,
                                     input logic [CW-1:0] post, input logic [CW-1:0] fs_i,
                                     input logic [CW-1:0] lf_i);
    logic [SW-1:0] sum;
    logic [SW-1:0] side;
    sum  = SW'(pre) + SW'(main) + SW'(post);
    side = SW'(pre) + SW'(post) + SW'(lf_i);
    return (pre <= (fs_i >> 2)) && (sum == SW'(fs_i)) && (SW'(main) >= side);
  endfunction

  assign ok = rules_met(coef[CW-1:0], coef[2*CW-1:CW], coef[3*CW-1:2*CW], fs, lf);
endmodule

// File: rtl/eqs_iter_ctr.sv
module eqs_iter_ctr #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [IW-1:0] lim,
  output logic          at_lim
);
  logic [IW-1:0] cnt;

  assign at_lim = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (inc && !at_lim) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eqs_aeq_gate.sv
module eqs_aeq_gate import eqs_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  st_t  st,
  input  logic is_root,
  input  logic rate_dn,
  input  logic rearm,
  output logic aeq_en
);
  logic kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kill <= 1'b0;
    else if (rate_dn) kill <= 1'b1;
    else if (rearm)   kill <= 1'b0;
  end

  assign aeq_en = aeq_wanted(st, is_root) & ~kill & ~rate_dn;
endmodule

// File: rtl/eq_phase_seq.sv
module eq_phase_seq import eqs_pkg::*; #(
  parameter int CW = 5,
  parameter int IW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_root,
  input  logic            p2_enter,
  input  logic            p3_enter,
  input  logic [3*CW-1:0] init_coef,
  input  logic [CW-1:0]   fs,
  input  logic [CW-1:0]   lf,
  input  logic            cand_vld,
  input  logic [3*CW-1:0] cand_coef,
  input  logic            coef_ack,
  input  logic            ber_ok,
  input  logic            timeout,
  input  logic [IW-1:0]   iter_lim,
  input  logic            rate_dn,
  output logic [1:0]      phase,
  output logic [1:0]      ec_out,
  output logic            aeq_en,
  output logic            coef_req,
  output logic [3*CW-1:0] coef_out,
  output logic [3*CW-1:0] final_coef,
  output logic            rcvr_lock,
  output logic            eq_err
);
  localparam int VW = 3 * CW;

  st_t           st;
  logic          pend;
  logic          conv;
  logic [VW-1:0] cur_coef;
  logic [VW-1:0] fin_coef;
  logic          err_q;

  // named events
  logic cand_ok, at_lim;
  logic loop_st, tuning, can_eval;
  logic conv_evt, take_cand, iter_exit, tmo_exit;
  logic p2_go, p3_go, lock_entry, cnt_clr;

  eqs_legal #(.CW(CW)) u_legal (
    .coef(cand_coef), .fs(fs), .lf(lf), .ok(cand_ok)
  );

  assign tuning    = (st == ST_P2) || (st == ST_P3);
  assign loop_st   = (st == ST_P2) || ((st == ST_P3) && !is_root);
  assign can_eval  = loop_st && !pend && !conv;
  assign conv_evt  = (can_eval && ber_ok) || ((st == ST_P3) && is_root && ber_ok);
  assign take_cand = can_eval && !ber_ok && !timeout && cand_vld && !at_lim && cand_ok;
  assign iter_exit = can_eval && !ber_ok && cand_vld && at_lim;
  assign tmo_exit  = tuning && timeout;
  assign p2_go     = p2_enter;
  assign p3_go     = !p2_go && (st == ST_P2) && conv && p3_enter && !timeout;
  assign lock_entry = !p2_go && (tmo_exit || iter_exit || ((st == ST_P3) && conv_evt));
  assign cnt_clr   = p2_go || p3_go;

  eqs_iter_ctr #(.IW(IW)) u_iter (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(take_cand),
    .lim(iter_lim), .at_lim(at_lim)
  );

  eqs_aeq_gate u_aeq (
    .clk(clk), .rst_n(rst_n), .st(st), .is_root(is_root),
    .rate_dn(rate_dn), .rearm(p2_go), .aeq_en(aeq_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pend     <= 1'b0;
      conv     <= 1'b0;
      cur_coef <= '0;
      fin_coef <= '0;
      err_q    <= 1'b0;
    end else if (p2_go) begin
      st       <= ST_P2;
      pend     <= 1'b0;
      conv     <= 1'b0;
      cur_coef <= init_coef;
      err_q    <= 1'b0;
    end else if (lock_entry) begin
      st       <= ST_LOCK;
      pend     <= 1'b0;
      fin_coef <= cur_coef;
      err_q    <= tmo_exit || iter_exit;
    end else if (p3_go) begin
      st   <= ST_P3;
      pend <= 1'b0;
      conv <= 1'b0;
      if (!is_root) cur_coef <= init_coef;
    end else begin
      if (take_cand) begin
        cur_coef <= cand_coef;
        pend     <= 1'b1;
      end else if (pend && coef_ack) begin
        pend <= 1'b0;
      end
      if (conv_evt && (st == ST_P2)) conv <= 1'b1;
    end
  end

  assign phase      = 2'(st);
  assign ec_out     = ec_of(st);
  assign coef_req   = pend;
  assign coef_out   = cur_coef;
  assign final_coef = fin_coef;
  assign rcvr_lock  = (st == ST_LOCK);
  assign eq_err     = err_q;
endmodule

// File: rtl/eq_phase_seq_chk.sv
module eq_phase_seq_chk #(
  parameter int CW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            is_root,
  input logic            rate_dn,
  input logic [CW-1:0]   fs,
  input logic [CW-1:0]   lf,
  input logic [1:0]      phase,
  input logic [1:0]      ec_out,
  input logic            aeq_en,
  input logic            coef_req,
  input logic [3*CW-1:0] coef_out,
  input logic [3*CW-1:0] final_coef,
  input logic            rcvr_lock,
  input logic            eq_err
);
  function automatic logic set_ok(input logic [3*CW-1:0] c, input logic [CW-1:0] f,
                                  input logic [CW-1:0] l);
    int p, m, q;
    p = int'(c[CW-1:0]);
    m = int'(c[2*CW-1:CW]);
    q = int'(c[3*CW-1:2*CW]);
    return (4 * p <= int'(f)) && (m == int'(f) - p - q) && (m - p - q >= int'(l));
  endfunction

  assert_aeq_role_R11: assert property (@(posedge clk) disable iff (!rst_n)
    aeq_en |-> ((phase == 2'd2) && !is_root) || ((phase == 2'd3) && is_root));

  assert_aeq_down_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rate_dn |-> !aeq_en);

  assert_root_no_tune_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_root && (phase == 2'd3)) |-> !coef_req);

  assert_final_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(final_coef) |-> $rose(rcvr_lock));

  assert_lock_ec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rcvr_lock |-> (ec_out == 2'b00) && (phase == 2'd1));

  assert_err_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eq_err |-> rcvr_lock);

  assert_req_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    coef_req |-> set_ok(coef_out, fs, lf));
endmodule

bind eq_phase_seq eq_phase_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_root(is_root), .rate_dn(rate_dn),
  .fs(fs), .lf(lf), .phase(phase), .ec_out(ec_out), .aeq_en(aeq_en),
  .coef_req(coef_req), .coef_out(coef_out), .final_coef(final_coef),
  .rcvr_lock(rcvr_lock), .eq_err(eq_err)
);

// File: tb/tb_eq_phase_seq.sv
module tb_eq_phase_seq;
  localparam int CW = 5;
  localparam int IW = 6;
  localparam int VW = 3 * CW;
  localparam int FS = 24;
  localparam int LF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_root = 1'b0, p2_enter = 1'b0, p3_enter = 1'b0;
  logic [VW-1:0] init_coef = '0, cand_coef = '0;
  logic [CW-1:0] fs = CW'(FS), lf = CW'(LF);
  logic cand_vld = 1'b0, coef_ack = 1'b0, ber_ok = 1'b0, timeout = 1'b0, rate_dn = 1'b0;
  logic [IW-1:0] iter_lim = IW'(5);
  logic [1:0] phase, ec_out;
  logic aeq_en, coef_req, rcvr_lock, eq_err;
  logic [VW-1:0] coef_out, final_coef;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eq_phase_seq #(.CW(CW), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .is_root(is_root), .p2_enter(p2_enter), .p3_enter(p3_enter),
    .init_coef(init_coef), .fs(fs), .lf(lf), .cand_vld(cand_vld), .cand_coef(cand_coef),
    .coef_ack(coef_ack), .ber_ok(ber_ok), .timeout(timeout), .iter_lim(iter_lim),
    .rate_dn(rate_dn), .phase(phase), .ec_out(ec_out), .aeq_en(aeq_en),
    .coef_req(coef_req), .coef_out(coef_out), .final_coef(final_coef),
    .rcvr_lock(rcvr_lock), .eq_err(eq_err)
  );

  function automatic logic [VW-1:0] mk(int pre, int main, int post);
    return {CW'(post), CW'(main), CW'(pre)};
  endfunction

  function automatic bit legal(int pre, int main, int post);
    return (pre <= FS / 4) && (pre + main + post == FS) && (main - pre - post >= LF);
  endfunction

  localparam logic [VW-1:0] P0 = {5'd4, 5'd18, 5'd2};
  localparam logic [VW-1:0] CA = {5'd4, 5'd19, 5'd1};
  localparam logic [VW-1:0] CB = {5'd4, 5'd20, 5'd0};
  localparam logic [VW-1:0] CC = {5'd4, 5'd17, 5'd3};
  localparam logic [VW-1:0] CX = {5'd4, 5'd13, 5'd7};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic start2(logic [VW-1:0] pre);
    init_coef = pre; p2_enter = 1'b1; cyc(); p2_enter = 1'b0;
  endtask

  task automatic propose(logic [VW-1:0] c);
    cand_coef = c; cand_vld = 1'b1; cyc(); cand_vld = 1'b0;
  endtask

  task automatic ack();
    coef_ack = 1'b1; cyc(); coef_ack = 1'b0;
  endtask

  task automatic ber();
    ber_ok = 1'b1; cyc(); ber_ok = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R13 reset state
    check("R13 phase", 32'(phase), 0);
    check("R13 outs", {aeq_en, coef_req, rcvr_lock, eq_err, ec_out}, 0);
    check("R13 coef", 32'(coef_out) | 32'(final_coef), 0);
    rst_n = 1'b1;
    cyc();

    // endpoint role
    is_root = 1'b0;
    start2(P0);
    check("R1 phase", 32'(phase), 2);
    check("R1 ec", 32'(ec_out), 2);
    check("R1 coef", 32'(coef_out), 32'(P0));
    check("R1 req", 32'(coef_req), 0);
    check("R11 ep p2 aeq", 32'(aeq_en), 1);

    // R2 / R3 sweep around the legality boundary
    for (int pre = 0; pre < 8; pre++)
      for (int post = 0; post < 16; post++)
        for (int d = -1; d <= 1; d++) begin
          int main = FS - pre - post + d;
          bit e;
          if (main < 0 || main > 31) continue;
          e = legal(pre, main, post);
          start2(P0);
          propose(mk(pre, main, post));
          check(e ? "R2 sweep req" : "R3 sweep req", 32'(coef_req), 32'(e));
          check(e ? "R2 sweep coef" : "R3 sweep coef", 32'(coef_out),
                32'(e ? mk(pre, main, post) : P0));
        end

    // R3 candidate ignored while pending; R2 ack releases
    start2(P0);
    propose(CA);
    propose(CB);
    check("R3 pending ignore", 32'(coef_out), 32'(CA));
    check("R2 req held", 32'(coef_req), 1);
    ack();
    check("R2 ack clears", 32'(coef_req), 0);

    // R4 convergence beats a same-cycle candidate
    start2(P0);
    cand_coef = CB; cand_vld = 1'b1; ber_ok = 1'b1; cyc(); cand_vld = 1'b0; ber_ok = 1'b0;
    check("R4 collide coef", 32'(coef_out), 32'(P0));
    check("R4 collide req", 32'(coef_req), 0);
    propose(CB);
    check("R4 after conv", 32'(coef_out), 32'(P0));

    // R5 early p3_enter ignored
    start2(P0);
    p3_enter = 1'b1; cyc(); p3_enter = 1'b0;
    check("R5 early p3", 32'(phase), 2);

    // endpoint full flow
    propose(CA); ack(); ber();
    p3_enter = 1'b1; cyc(); p3_enter = 1'b0;
    check("R5 p3 phase", 32'(phase), 3);
    check("R5 p3 ec", 32'(ec_out), 3);
    check("R5 ep reload", 32'(coef_out), 32'(P0));
    check("R11 ep p3 aeq", 32'(aeq_en), 0);
    propose(CC); ack();
    check("R7 ep p3 loop", 32'(coef_out), 32'(CC));
    ber();
    check("R7 ep lock", 32'(rcvr_lock), 1);
    check("R7 ep final", 32'(final_coef), 32'(CC));
    check("R8 lock phase ec", {30'd0, phase} | (32'(ec_out) << 4), 1);
    check("R8 no err", 32'(eq_err), 0);
    check("R11 lock aeq", 32'(aeq_en), 0);
    propose(CA); ack();
    timeout = 1'b1; cyc(); timeout = 1'b0;
    check("R8 lock hold final", 32'(final_coef), 32'(CC));
    check("R8 lock stays", {rcvr_lock, eq_err}, 2);
    start2(P0);
    check("R8 final after p2", 32'(final_coef), 32'(CC));

    // R9 iteration limit sweep
    for (int lim = 0; lim < 5; lim++) begin
      logic [VW-1:0] last;
      iter_lim = IW'(lim);
      start2(P0);
      last = P0;
      for (int k = 0; k < lim; k++) begin
        last = (k % 2 == 0) ? CA : CB;
        propose(last); ack();
        check("R9 not yet", 32'(rcvr_lock), 0);
      end
      propose(CX);
      check("R9 limit lock", {rcvr_lock, eq_err}, 3);
      check("R9 limit final", 32'(final_coef), 32'(last));
    end
    iter_lim = IW'(5);

    // R10 timeout
    start2(P0);
    propose(CB);
    timeout = 1'b1; cyc(); timeout = 1'b0;
    check("R10 tmo lock", {rcvr_lock, eq_err}, 3);
    check("R10 tmo final", 32'(final_coef), 32'(CB));
    start2(P0);
    check("R1 err cleared", 32'(eq_err), 0);

    // R12 rate downshift with phase-2 entry for endpoint
    init_coef = P0; p2_enter = 1'b1; rate_dn = 1'b1; cyc(); p2_enter = 1'b0; rate_dn = 1'b0;
    #1 check("R12 kill at entry", 32'(aeq_en), 0);
    start2(P0);
    check("R12 rearm", 32'(aeq_en), 1);

    // root role
    is_root = 1'b1;
    start2(P0);
    check("R11 root p2 aeq", 32'(aeq_en), 0);
    propose(CA); ack(); ber();
    p3_enter = 1'b1; cyc(); p3_enter = 1'b0;
    check("R6 root p3 phase", 32'(phase), 3);
    check("R6 root keep p2 set", 32'(coef_out), 32'(CA));
    check("R11 root p3 aeq", 32'(aeq_en), 1);
    propose(CB);
    check("R6 root no req", 32'(coef_req), 0);
    check("R6 root no apply", 32'(coef_out), 32'(CA));
    rate_dn = 1'b1;
    #1 check("R12 same cycle", 32'(aeq_en), 0);
    cyc(); rate_dn = 1'b0;
    #1 check("R12 stays off", 32'(aeq_en), 0);
    ber();
    check("R6 root lock", 32'(rcvr_lock), 1);
    check("R7 root final", 32'(final_coef), 32'(CA));
    check("R8 root ec", 32'(ec_out), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule